// File: doc/BRIEF.md
# MDIO Station-Management Master

This block lets software talk to external PHY devices over the two-wire management bus, with one clock line (MDC) and one bidirectional data line (MDIO). Software programs a small bank of word registers through a simple write/read port. It sets an enable bit, picks Clause 22 or Clause 45 framing and the optional preamble, and loads write data. It then writes a command word, and that write launches exactly one frame on the wire.

The block divides the system clock down to MDC. It shifts out the preamble, start, opcode, port address, register or device address, turnaround and 16-bit data, and it releases the data line whenever the PHY must drive it. The 16 bits it captures on a read are returned in the read-data register. Progress is reported through a pending flag in the write-data register for write and address frames, and through pending and valid flags in the read-data register for reads.

A Clause 45 register access takes two commands from software: an address frame carrying the register number in the write-data register, then a read or write frame aimed at the device.

Top module: `mdio_master`

## Requirements
- R1: After reset MDC and the MDIO output enable are low, and every register reads zero.
- R2: MDC is the system clock divided by the even parameter DIV (default 4) with 50% duty. It rises DIV/2 cycles after reset and then toggles every DIV/2 cycles.
- R3: The command register (word 2) holds the register or device address in bits 4:0, the PHY address in bits 12:8 and the operation code in bits 17:16. In Clause 22 mode code 0 sends start 01, wire opcode 01, turnaround 10 and the 16 write-data bits. Code 1 sends start 01 and wire opcode 10. Both fields are sent MSB first.
- R4: With bit 24 of the mode register (word 1) set, frames use start 00. Code 0 is an address frame with wire opcode 00 that carries write data. Code 1 is a write with wire opcode 01. Code 3 is a read with wire opcode 11.
- R5: Bit 12 of the mode register prefixes each frame with 32 ones. When that bit is clear, the frame begins directly with the start bits.
- R6: A command written while bit 0 of the enable register (word 0) is clear starts no frame.
- R7: On a read the output enable is low for both turnaround bits and all 16 data bits. Data is sampled MSB first at MDC rising edges and appears in read-data (word 4) bits 15:0. The output enable is low whenever no frame is in flight.
- R8: Bit 17 of the write-data register (word 3) reads 1 from the cycle after a write or address command is accepted until that frame ends, and 0 otherwise. Bits 15:0 read back the loaded data.
- R9: Read-data bit 17 is 1 while a read frame is in flight. Bit 16 clears when a new read starts and sets once the captured word is stored.
- R10: A command written while a frame is in flight is ignored: the wire frame and the command readback are unchanged.
- R11: Unsupported codes start nothing: codes 2 and 3 in Clause 22 mode, and code 2 in Clause 45 mode.
- R12: The master changes MDIO only at the system-clock edge where MDC falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line input from the pad |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
Several properties are checked on every cycle. MDC may only toggle after a divider event. MDIO may only change together with a falling MDC, and it is never driven while idle. No frame may start while the enable bit is clear. The latched operation must stay fixed for the whole frame, and the valid flag must already be clear when a read goes pending. The exact bit order of each frame type, the turnaround release, the captured read word, and whether a command was ignored while busy or for an illegal code can only be shown by the scenarios. In those scenarios a behavioural model queues the expected wire bits and compares MDC, the output enable and the driven data on every cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [2:0] REG_EN   = 3'd0;
  localparam logic [2:0] REG_MODE = 3'd1;
  localparam logic [2:0] REG_CMD  = 3'd2;
  localparam logic [2:0] REG_WDAT = 3'd3;
  localparam logic [2:0] REG_RDAT = 3'd4;

  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;

  // Code legality per framing mode.
  function automatic logic cmd_legal(input logic c45, input logic [1:0] code);
    return c45 ? (code != 2'd2) : (code[1] == 1'b0);
  endfunction

  function automatic logic cmd_is_read(input logic c45, input logic [1:0] code);
    return c45 ? (code == 2'd3) : (code == 2'd1);
  endfunction

  // Opcode bits as they appear on the wire.
  function automatic logic [1:0] wire_op(input logic c45, input logic [1:0] code);
    if (c45) return code;
    return (code == 2'd1) ? 2'b10 : 2'b01;
  endfunction

  // 32-bit frame body: start, opcode, port, register, turnaround, data.
  function automatic logic [31:0] frame_word(input logic c45, input logic [1:0] code,
                                             input logic [4:0] phy, input logic [4:0] ra,
                                             input logic [15:0] data);
    logic rd;
    rd = cmd_is_read(c45, code);
    return {(c45 ? 2'b00 : 2'b01), wire_op(c45, code), phy, ra,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : data)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_evt = (cnt == CW'(HALF - 1));
  assign fall_evt = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_evt ? '0 : cnt + 1'b1;
      if (rise_evt) mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        start_go,
  input  logic        c45,
  input  logic        pre_en,
  input  logic [1:0]  go_code,
  input  logic [4:0]  go_phy,
  input  logic [4:0]  go_reg,
  input  logic [15:0] go_data,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        cur_read,
  output logic [1:0]  cur_op,
  output logic        rd_done,
  output logic [15:0] rd_word
);
  localparam int SW = PRE_BITS + FRAME_BITS;
  localparam int NW = $clog2(SW + 1);
  localparam int TA_DATA = 18;

  logic [SW-1:0] shreg;
  logic [NW-1:0] remain;
  logic [NW-1:0] remain_nx;

  assign remain_nx = remain - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      remain   <= '0;
      busy     <= 1'b0;
      cur_read <= 1'b0;
      cur_op   <= 2'd0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_done  <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_done <= 1'b0;
      if (start_go) begin
        if (pre_en)
          shreg <= {{PRE_BITS{1'b1}}, frame_word(c45, go_code, go_phy, go_reg, go_data)};
        else
          shreg <= {frame_word(c45, go_code, go_phy, go_reg, go_data), {PRE_BITS{1'b1}}};
        remain   <= pre_en ? NW'(SW) : NW'(FRAME_BITS);
        busy     <= 1'b1;
        cur_read <= cmd_is_read(c45, go_code);
        cur_op   <= go_code;
        rd_word  <= '0;
      end else if (busy && fall_evt) begin
        if (remain == '0) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          rd_done <= cur_read;
        end else begin
          mdio_o  <= shreg[SW-1];
          shreg   <= {shreg[SW-2:0], 1'b1};
          remain  <= remain_nx;
          mdio_oe <= !(cur_read && (remain_nx < NW'(TA_DATA)));
        end
      end
      if (busy && rise_evt && cur_read && (remain < NW'(16)))
        rd_word <= {rd_word[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        busy,
  input  logic        cur_read,
  input  logic        rd_done,
  input  logic [15:0] rd_word,
  output logic        en_q,
  output logic        c45_q,
  output logic        pre_q,
  output logic [15:0] wdat_q,
  output logic        start_go,
  output logic        rd_valid,
  output logic        wr_pend,
  output logic        rd_pend
);
  logic [17:0] cmd_q;
  logic [15:0] rdat_q;

  assign wr_pend  = busy && !cur_read;
  assign rd_pend  = busy && cur_read;
  assign start_go = bus_we && (bus_addr == REG_CMD) && en_q && !busy &&
                    cmd_legal(c45_q, bus_wdata[17:16]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      c45_q    <= 1'b0;
      pre_q    <= 1'b0;
      wdat_q   <= '0;
      cmd_q    <= '0;
      rdat_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (bus_we) begin
        unique case (bus_addr)
          REG_EN:   en_q <= bus_wdata[0];
          REG_MODE: begin
            c45_q <= bus_wdata[24];
            pre_q <= bus_wdata[12];
          end
          REG_WDAT: wdat_q <= bus_wdata[15:0];
          default: ;
        endcase
      end
      if (start_go) begin
        cmd_q <= {bus_wdata[17:16], 3'b000, bus_wdata[12:8], 3'b000, bus_wdata[4:0]};
        if (cmd_is_read(c45_q, bus_wdata[17:16])) rd_valid <= 1'b0;
      end
      if (rd_done) begin
        rdat_q   <= rd_word;
        rd_valid <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_EN:   bus_rdata[0] = en_q;
      REG_MODE: begin
        bus_rdata[24] = c45_q;
        bus_rdata[12] = pre_q;
      end
      REG_CMD:  bus_rdata[17:0] = cmd_q;
      REG_WDAT: bus_rdata = {14'd0, wr_pend, 1'b0, wdat_q};
      REG_RDAT: bus_rdata = {14'd0, rd_pend, rd_valid, rdat_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic        rise_evt, fall_evt;
  logic        en_q, c45_q, pre_q, start_go, rd_valid, wr_pend, rd_pend;
  logic        busy, cur_read, rd_done;
  logic [1:0]  cur_op;
  logic [15:0] wdat_q, rd_word;

  mdio_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .cur_read(cur_read),
    .rd_done(rd_done), .rd_word(rd_word), .en_q(en_q), .c45_q(c45_q), .pre_q(pre_q),
    .wdat_q(wdat_q), .start_go(start_go), .rd_valid(rd_valid), .wr_pend(wr_pend),
    .rd_pend(rd_pend)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .start_go(start_go), .c45(c45_q), .pre_en(pre_q), .go_code(bus_wdata[17:16]),
    .go_phy(bus_wdata[12:8]), .go_reg(bus_wdata[4:0]), .go_data(wdat_q),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
    .cur_read(cur_read), .cur_op(cur_op), .rd_done(rd_done), .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       start_go,
  input logic       en_q,
  input logic [1:0] cur_op,
  input logic       rd_pend,
  input logic       rd_valid,
  input logic       rise_evt,
  input logic       fall_evt
);
  AST_MDC_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(rise_evt || fall_evt)); // R2

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |-> en_q); // R6

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R7

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_pend) |-> !rd_valid); // R9

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_op)); // R10

  AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && !$stable(mdio_o)) |-> $fell(mdc)); // R12
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .start_go(start_go), .en_q(en_q), .cur_op(cur_op),
  .rd_pend(rd_pend), .rd_valid(rd_valid), .rise_evt(rise_evt), .fall_evt(fall_evt)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int vectors = 0;
  int miscompares = 0;

  // Reference model state
  int       m_cnt = 0;
  bit       m_mdc = 0, m_busy = 0, m_rd = 0, m_o = 1, m_oe = 0, m_live = 0;
  int       m_rem = 99;
  bit       m_en = 0, m_c45 = 0, m_pre = 0;
  bit [15:0] m_wdat = 0;
  bit       m_q[$];
  bit [15:0] phy_resp = 16'h0000;

  assign mdio_i = (m_busy && m_rd && m_live && m_rem < 16) ? phy_resp[m_rem] : 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV(DIV)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  function automatic void push_field(input int n, input bit [15:0] v);
    for (int i = n - 1; i >= 0; i--) m_q.push_back(v[i]);
  endfunction

  function automatic bit legal(input bit c45, input bit [1:0] code);
    if (c45) return code == 2'd0 || code == 2'd1 || code == 2'd3;
    return code == 2'd0 || code == 2'd1;
  endfunction

  // Builds the expected wire bits from the requirement text.
  function automatic void load_frame(input bit [1:0] code, input bit [4:0] phy,
                                     input bit [4:0] ra);
    bit rd;
    rd = m_c45 ? (code == 2'd3) : (code == 2'd1);
    m_q.delete();
    if (m_pre) push_field(32, 16'hFFFF);
    if (m_pre) m_q.delete();
    if (m_pre) for (int i = 0; i < 32; i++) m_q.push_back(1'b1);
    if (m_c45) begin
      push_field(2, 2'b00);
      case (code)
        2'd0: push_field(2, 2'b00);
        2'd1: push_field(2, 2'b01);
        default: push_field(2, 2'b11);
      endcase
    end else begin
      push_field(2, 2'b01);
      push_field(2, rd ? 2'b10 : 2'b01);
    end
    push_field(5, phy);
    push_field(5, ra);
    push_field(2, rd ? 2'b11 : 2'b10);
    push_field(16, rd ? 16'hFFFF : m_wdat);
    m_rd = rd;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mdc = 0; m_busy = 0; m_rd = 0; m_o = 1; m_oe = 0; m_live = 0;
      m_rem = 99; m_en = 0; m_c45 = 0; m_pre = 0; m_wdat = 0; m_q.delete();
    end else begin
      bit rise, fall, was_busy;
      rise = (m_cnt == DIV/2 - 1);
      fall = (m_cnt == DIV - 1);
      was_busy = m_busy;
      m_cnt = fall ? 0 : m_cnt + 1;
      if (rise) m_mdc = 1;
      if (fall) m_mdc = 0;
      if (m_busy && fall) begin
        if (m_q.size() == 0) begin
          m_busy = 0; m_oe = 0; m_live = 0; m_rem = 99;
        end else begin
          m_o = m_q.pop_front();
          m_rem = m_q.size();
          m_live = 1;
          m_oe = !(m_rd && m_rem <= 17);
        end
      end
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_en = bus_wdata[0];
          3'd1: begin m_c45 = bus_wdata[24]; m_pre = bus_wdata[12]; end
          3'd2: if (m_en && !was_busy && legal(m_c45, bus_wdata[17:16])) begin
                  load_frame(bus_wdata[17:16], bus_wdata[12:8], bus_wdata[4:0]);
                  m_busy = 1; m_live = 0; m_rem = 99;
                end
          3'd3: m_wdat = bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (mdc !== m_mdc || mdio_oe !== m_oe || (m_oe && mdio_o !== m_o)) begin
        miscompares++;
        $display("FAIL R2/R3/R7/R12 cycle: mdc=%b oe=%b o=%b expected mdc=%b oe=%b o=%b",
                 mdc, mdio_oe, mdio_o, m_mdc, m_oe, m_o);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (m_busy && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] cmdw(input bit [1:0] code, input bit [4:0] phy,
                                       input bit [4:0] ra);
    return {14'd0, code, 3'd0, phy, 3'd0, ra};
  endfunction

  initial begin
    repeat (25000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(mdc === 1'b0 || mdc === 1'b1, "R1 mdc known", {31'd0, mdc}, 32'd0);
    check(mdio_oe === 1'b0, "R1 oe", {31'd0, mdio_oe}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      bus_read(3'(a), r);
      check(r === 32'd0, "R1 register reset", r, 32'd0);
    end

    // R6: command with enable clear is ignored
    bus_write(3'd3, 32'h0000_1111);
    bus_write(3'd2, cmdw(2'd0, 5'd3, 5'd4));
    repeat (20) @(negedge clk);
    bus_read(3'd3, r);
    check(r[17] === 1'b0, "R6 no pending when disabled", r, 32'h0000_1111);
    check(mdio_oe === 1'b0, "R6 line released", {31'd0, mdio_oe}, 32'd0);

    // R3 R5 R8 R10: Clause 22 write with preamble, second command while busy
    bus_write(3'd0, 32'd1);
    bus_write(3'd1, 32'h0000_1000);
    bus_write(3'd3, 32'h0000_A5C3);
    bus_write(3'd2, cmdw(2'd0, 5'd5, 5'h12));
    bus_read(3'd3, r);
    check(r === 32'h0002_A5C3, "R8 write pending set", r, 32'h0002_A5C3);
    bus_write(3'd2, cmdw(2'd0, 5'd9, 5'h01));
    bus_read(3'd2, r);
    check(r === cmdw(2'd0, 5'd5, 5'h12), "R10 command readback", r, cmdw(2'd0, 5'd5, 5'h12));
    wait_idle();
    bus_read(3'd3, r);
    check(r[17] === 1'b0, "R8 write pending clear", r, 32'h0000_A5C3);

    // R7 R9 R5: Clause 22 read without preamble
    bus_write(3'd1, 32'h0000_0000);
    phy_resp = 16'h9E37;
    bus_write(3'd2, cmdw(2'd1, 5'd1, 5'h02));
    bus_read(3'd4, r);
    check(r[17:16] === 2'b10, "R9 read pending, valid low", r, 32'h0002_0000);
    wait_idle();
    bus_read(3'd4, r);
    check(r === 32'h0001_9E37, "R7 captured word", r, 32'h0001_9E37);

    // R11: unsupported Clause 22 code
    bus_write(3'd2, cmdw(2'd2, 5'd1, 5'h02));
    @(negedge clk);
    bus_read(3'd4, r);
    check(r === 32'h0001_9E37, "R11 c22 code 2 ignored", r, 32'h0001_9E37);
    bus_write(3'd2, cmdw(2'd3, 5'd1, 5'h02));
    bus_read(3'd4, r);
    check(r === 32'h0001_9E37, "R11 c22 code 3 ignored", r, 32'h0001_9E37);

    // R4: Clause 45 address, write, read
    bus_write(3'd1, 32'h0100_1000);
    bus_write(3'd3, 32'h0000_4321);
    bus_write(3'd2, cmdw(2'd0, 5'd7, 5'd3));
    bus_read(3'd3, r);
    check(r[17] === 1'b1, "R8 address frame pending", r, 32'h0002_4321);
    wait_idle();
    bus_write(3'd3, 32'h0000_0F0F);
    bus_write(3'd2, cmdw(2'd1, 5'd7, 5'd3));
    wait_idle();
    bus_read(3'd3, r);
    check(r === 32'h0000_0F0F, "R4 c45 write done", r, 32'h0000_0F0F);
    phy_resp = 16'h1234;
    bus_write(3'd2, cmdw(2'd3, 5'd7, 5'd3));
    bus_read(3'd4, r);
    check(r[16] === 1'b0, "R9 valid cleared on new read", r, 32'h0002_0000);
    wait_idle();
    bus_read(3'd4, r);
    check(r === 32'h0001_1234, "R4 c45 read word", r, 32'h0001_1234);

    // R11: Clause 45 code 2
    bus_write(3'd2, cmdw(2'd2, 5'd7, 5'd3));
    bus_read(3'd4, r);
    check(r[17] === 1'b0, "R11 c45 code 2 ignored", r, 32'h0001_1234);
    repeat (8) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule